// File: doc/BRIEF.md
# Configurable Multilevel Routing Multiplexer

An N:1 selector for programmable routing fabrics, steered by static configuration bits that an external register holds stable. The data path has no clock. It is a stack of branch stages: each branch of a stage picks one of its inputs, and the last stage yields a single output. A structure parameter picks one of three forms:

- a flat form, with one enable bit per input;
- a stacked form, where every branch of a stage shares one one-hot select field;
- a binary tree, with one select bit per stage.

The branch width and the stage count are derived at elaboration from the input count and the requested depth. When the branch grid holds more leaves than there are inputs, the spare leaves are tied to 0. A select field that is not exactly one-hot forces the output low and raises an error flag.

Top module: `routing_mux`

## Requirements
- R1: Flat form (STRUCT=0) has N configuration bits; bit i set alone routes data_i[i] to data_o.
- R2: Stacked form (STRUCT=1) has K*L configuration bits. The field of stage s is cfg_i[s*K +: K], with stage 0 nearest the inputs. Setting bit j of that field takes branch input j. Input index i is written in base K with stage 0 as the least significant digit, and each digit names the bit to set in its stage.
- R3: Branch width K follows fixed rules. For L=2, K is the smallest integer whose square is at least N. For L>2, K is the smallest integer of at least 2 whose L-th power is at least N. For L=1, K=N. Examples: N=5,L=2 gives K=3; N=17,L=3 gives K=3.
- R4: Tree form (STRUCT=2) has ceil(log2 N) configuration bits. When bit s is 1, each pair at stage s takes its even (first) input; when it is 0, it takes the odd one. Input i is therefore reached with cfg_i[s] = NOT i[s].
- R5: When N=2, the tree form with one configuration bit is built whatever structure is requested.
- R6: A leaf position with index at least N reads as 0.
- R7: In the flat and stacked forms, a stage field with zero bits set or with more than one bit set drives data_o to 0 and cfg_err_o to 1. Otherwise cfg_err_o is 0. The tree form never raises cfg_err_o.
- R8: data_o and cfg_err_o follow data_i and cfg_i combinationally, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | N | Data inputs to be routed |
| cfg_i | input | CFG_W (N, K*L or ceil(log2 N)) | Static configuration bits |
| data_o | output | 1 | Routed output |
| cfg_err_o | output | 1 | Select field not one-hot |

## Verification
Every legal input index is selected for N of 2, 5, 8 and 17, across all three forms, including N=17 at three stages and a 2-input instance that requests the stacked form.

- **Walking one.** For each index, a single one is walked over all inputs. This separates the chosen input from every neighbour and catches a mis-ordered digit or a swapped stage field.
- **Walking zero.** An all-ones word with only the chosen input cleared shows that no other input leaks through.
- **Spare leaves and bad fields.** A spare leaf is selected with all data high, and select fields are made empty or doubly set. These show that the spare leaves are tied low and that the error path forces the output to 0.

// File: rtl/rmux_pkg.sv
package rmux_pkg;
  localparam int RM_FLAT  = 0;
  localparam int RM_STACK = 1;
  localparam int RM_TREE  = 2;

  function automatic int pow_i(input int b, input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  function automatic int clog2_i(input int n);
    int r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  function automatic bit is_tree(input int n, input int st);
    return (n == 2) || (st == RM_TREE);
  endfunction

  function automatic int branch_w(input int n, input int st, input int lv);
    int k;
    if (is_tree(n, st)) return 2;
    if (st == RM_FLAT || lv == 1) return n;
    if (lv == 2) begin
      k = 1;
      while (k * k < n) k++;
      return k;
    end
    k = 2;
    while (pow_i(k, lv) < n) k++;
    return k;
  endfunction

  function automatic int stage_cnt(input int n, input int st, input int lv);
    if (is_tree(n, st)) return clog2_i(n);
    if (st == RM_FLAT) return 1;
    return lv;
  endfunction

  function automatic int cfg_w(input int n, input int st, input int lv);
    if (is_tree(n, st)) return clog2_i(n);
    return branch_w(n, st, lv) * stage_cnt(n, st, lv);
  endfunction
endpackage

// File: rtl/rmux_onehot_stage.sv
module rmux_onehot_stage #(
  parameter int K  = 3,
  parameter int NB = 1
) (
  input  logic [NB*K-1:0] in_i,
  input  logic [K-1:0]    sel_i,
  output logic [NB-1:0]   out_o,
  output logic            err_o
);
  always_comb begin
    err_o = ($countones(sel_i) != 1);
    for (int b = 0; b < NB; b++)
      out_o[b] = err_o ? 1'b0 : |(in_i[b*K +: K] & sel_i);
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      // R2
      if (out_o[b]) oh_src_chk: assert (|in_i[b*K +: K])
        else $error("branch output high with all inputs low");
    end
  end
endmodule

// File: rtl/rmux_pair_stage.sv
module rmux_pair_stage #(
  parameter int NB = 1
) (
  input  logic [NB*2-1:0] in_i,
  input  logic            sel_i,
  output logic [NB-1:0]   out_o
);
  always_comb begin
    for (int b = 0; b < NB; b++)
      out_o[b] = sel_i ? in_i[2*b] : in_i[2*b+1];
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      // R4
      pair_pick_chk: assert (out_o[b] == in_i[2*b] || out_o[b] == in_i[2*b+1])
        else $error("pair output matches neither input");
    end
  end
endmodule

// File: rtl/routing_mux.sv
module routing_mux #(
  parameter int N      = 5,
  parameter int STRUCT = rmux_pkg::RM_STACK,
  parameter int LEVELS = 2
) (
  input  logic [N-1:0]                                  data_i,
  input  logic [rmux_pkg::cfg_w(N, STRUCT, LEVELS)-1:0] cfg_i,
  output logic                                          data_o,
  output logic                                          cfg_err_o
);
  import rmux_pkg::*;

  localparam bit TREE   = is_tree(N, STRUCT);
  localparam int K      = branch_w(N, STRUCT, LEVELS);
  localparam int LV     = stage_cnt(N, STRUCT, LEVELS);
  localparam int LEAVES = pow_i(K, LV);

  if (K < 2 || LV < 1) begin : g_bad_cfg
    $error("routing_mux: branch width below 2 is illegal");
  end

  logic [LEAVES-1:0] leaf_w;
  assign leaf_w = LEAVES'(data_i);  // R6: spare leaves tied low

  for (genvar s = 0; s < LV; s++) begin : g_st
    localparam int W  = pow_i(K, LV - s);
    localparam int NB = W / K;
    logic [W-1:0]  src;
    logic [NB-1:0] nxt;
    logic          err_acc;

    if (s == 0) begin : g_first
      assign src = leaf_w;
    end else begin : g_chain
      assign src = g_st[s-1].nxt;
    end

    if (TREE) begin : g_pair
      rmux_pair_stage #(.NB(NB)) u_stage (
        .in_i (src),
        .sel_i(cfg_i[s]),
        .out_o(nxt)
      );
      if (s == 0) begin : g_e0
        assign err_acc = 1'b0;
      end else begin : g_en
        assign err_acc = g_st[s-1].err_acc;
      end
    end else begin : g_oh
      logic st_err;
      rmux_onehot_stage #(.K(K), .NB(NB)) u_stage (
        .in_i (src),
        .sel_i(cfg_i[s*K +: K]),
        .out_o(nxt),
        .err_o(st_err)
      );
      if (s == 0) begin : g_e0
        assign err_acc = st_err;
      end else begin : g_en
        assign err_acc = st_err | g_st[s-1].err_acc;
      end
    end
  end

  assign data_o    = g_st[LV-1].nxt[0];
  assign cfg_err_o = g_st[LV-1].err_acc;

  always_comb begin
    // R7
    if (cfg_err_o) err_quiet_chk: assert (!data_o)
      else $error("output high while select field is bad");
    // R7
    if (TREE) tree_no_err_chk: assert (!cfg_err_o)
      else $error("tree form raised select error");
    // R8
    if (data_i == '0) zero_in_chk: assert (!data_o)
      else $error("output high with all inputs low");
  end
endmodule

// File: tb/routing_mux_test.sv
module routing_mux_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit timeout = 1'b0;

  function automatic int kb(input int n, input int l);
    int k;
    if (l == 1) return n;
    k = 2;
    for (;;) begin
      int p = 1;
      for (int j = 0; j < l; j++) p = p * k;
      if (p >= n) return k;
      k++;
    end
  endfunction

  localparam int K5  = kb(5, 2);
  localparam int K17 = kb(17, 3);

  logic [31:0] dat  = '0;
  logic [31:0] cfgv = '0;
  wire  [4:0]  o, e;

  routing_mux #(.N(5),  .STRUCT(1), .LEVELS(2)) uut  (.data_i(dat[4:0]),  .cfg_i(cfgv[K5*2-1:0]),  .data_o(o[0]), .cfg_err_o(e[0]));
  routing_mux #(.N(8),  .STRUCT(2), .LEVELS(2)) u_t8 (.data_i(dat[7:0]),  .cfg_i(cfgv[2:0]),       .data_o(o[1]), .cfg_err_o(e[1]));
  routing_mux #(.N(17), .STRUCT(1), .LEVELS(3)) u_m17(.data_i(dat[16:0]), .cfg_i(cfgv[K17*3-1:0]), .data_o(o[2]), .cfg_err_o(e[2]));
  routing_mux #(.N(17), .STRUCT(0), .LEVELS(1)) u_f17(.data_i(dat[16:0]), .cfg_i(cfgv[16:0]),      .data_o(o[3]), .cfg_err_o(e[3]));
  routing_mux #(.N(2),  .STRUCT(1), .LEVELS(2)) u_n2 (.data_i(dat[1:0]),  .cfg_i(cfgv[0:0]),       .data_o(o[4]), .cfg_err_o(e[4]));

  function automatic logic [31:0] mcfg(input int i, input int k, input int l);
    logic [31:0] r = '0;
    int d = i;
    for (int s = 0; s < l; s++) begin
      r[s*k + d % k] = 1'b1;
      d = d / k;
    end
    return r;
  endfunction

  function automatic logic [31:0] tcfg(input int i, input int l);
    logic [31:0] r = '0;
    for (int s = 0; s < l; s++) r[s] = ~((i >> s) & 1);
    return r;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic [31:0] c);
    @(posedge clk);
    #1ns;
    dat  = d;
    cfgv = c;
    #2ns;
  endtask

  task automatic sweep(input int w, input int n, input int k, input int l,
                       input bit tree, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] c = tree ? tcfg(i, l) : mcfg(i, k, l);
      for (int p = 0; p < n; p++) begin
        apply(32'd1 << p, c);
        chk($sformatf("%s walk1 sel=%0d hot=%0d", tag, i, p), o[w], (p == i));
        chk($sformatf("%s err sel=%0d", tag, i), e[w], 1'b0);
      end
      apply(~(32'd1 << i), c);
      chk($sformatf("%s walk0 sel=%0d", tag, i), o[w], 1'b0);
    end
  endtask

  task automatic run;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1ns;
    // reset-state inputs all low: stacked flags, tree does not
    chk("R7 idle stacked err", e[0], 1'b1);
    chk("R7 idle stacked out", o[0], 1'b0);
    chk("R7 idle tree err", e[1], 1'b0);
    chk("R8 idle tree out", o[1], 1'b0);

    sweep(0, 5, K5, 2, 1'b0, "R2 R3 n5");
    sweep(1, 8, 2, 3, 1'b1, "R4 n8");
    sweep(2, 17, K17, 3, 1'b0, "R2 R3 n17");
    sweep(3, 17, 17, 1, 1'b0, "R1 n17");
    sweep(4, 2, 2, 1, 1'b1, "R5 n2");

    // R6: spare leaves read 0
    apply('1, mcfg(7, K5, 2));
    chk("R6 n5 leaf7", o[0], 1'b0);
    chk("R6 n5 leaf7 err", e[0], 1'b0);
    apply('1, mcfg(20, K17, 3));
    chk("R6 n17 leaf20", o[2], 1'b0);
    apply('1, mcfg(26, K17, 3));
    chk("R6 n17 leaf26", o[2], 1'b0);

    // R7: bad select fields
    apply('1, 32'b100_011);
    chk("R7 n5 double stage0 err", e[0], 1'b1);
    chk("R7 n5 double stage0 out", o[0], 1'b0);
    apply('1, 32'b000_001);
    chk("R7 n5 empty stage1 err", e[0], 1'b1);
    chk("R7 n5 empty stage1 out", o[0], 1'b0);
    apply('1, 32'h0000_0003);
    chk("R7 flat double err", e[3], 1'b1);
    chk("R7 flat double out", o[3], 1'b0);
    apply('1, 32'h0);
    chk("R7 flat empty err", e[3], 1'b1);
    chk("R4 tree all-zero picks 7", o[1], 1'b1);
    chk("R7 tree no err", e[1], 1'b0);

    // R8: output follows data with no clock edge in between
    apply(32'd1 << 3, tcfg(3, 3));
    chk("R8 tree before", o[1], 1'b1);
    dat = 32'd0;
    #1ns;
    chk("R8 tree after data change", o[1], 1'b0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule